// File: doc/BRIEF.md
# Fine-Trim Tone Generator

This block produces a square-wave note for an alarm or buzzer pin from a 65536 Hz tick enable. It keeps an 8-bit note counter. The low seven bits time one half of the note period and the top bit is the note itself. Each time the low bits reach the programmed half-period length, they restart and the top bit flips. A trim bit in the setting shortens every low half by one tick, so the full period can be set in steps of one tick: 2N ticks without trim, 2N-1 ticks with trim.

The setting register is written through a one-cycle write strobe. A new value waits in a pending copy and becomes active at the next half-period boundary, or at once while the clear input is held, so a running note never produces a torn half. When tone mode is off, the alarm pin instead carries a fixed 4096 Hz tone derived from the same tick. An alarm-enable input gates the pin to 0. A complementary pin always carries the inverse of the alarm pin.

Top module: `tone_trim_gen`

## Requirements
- R1: After reset the note counter is zero, and while counting is disabled with alarm enable at 1 and tone mode selected, alarm_out is 0 and alarm_out_n is 1.
- R2: The setting has bit 7 as the trim bit and bits 6:0 as N, valid from 2 to 127. With bit 7 at 0 the note period is 2N ticks.
- R3: Every high half of the note lasts exactly N ticks. At the end of a low half the low counter bits restart at 0.
- R4: With setting bit 7 at 1, the low bits restart at 1 at the end of each high half. Each low half then lasts N-1 ticks, and the period is 2N-1 ticks.
- R5: While alarm_en is 0, alarm_out is 0 whatever the mode or counter state.
- R6: While tone_mode is 0, the note counter does not move, and with alarm_en at 1 alarm_out is a square wave of 16 ticks period, 8 ticks high (4096 Hz from a 65536 Hz tick).
- R7: While clr is 1 the note counter is held at zero. After clr falls, the first rising note edge comes after exactly N ticks.
- R8: While count_en is 0, the note counter holds its value and alarm_out does not change.
- R9: A setting write takes effect at the next half-period boundary. The half in progress keeps its old length.
- R10: alarm_out_n is always the inverse of alarm_out.
- R11: The note counter advances only on cycles where tick is 1. Note timing therefore scales with the tick spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle enable at the 65536 Hz note rate |
| tone_mode | input | 1 | 1 selects the note counter, 0 selects the fixed 4096 Hz tone |
| count_en | input | 1 | 1 lets the note counter advance |
| clr | input | 1 | 1 forces the note counter to zero and holds it there |
| set_wr | input | 1 | Write strobe for the setting register |
| set_data | input | 8 | Setting value: bit 7 trim, bits 6:0 half-period length N |
| alarm_en | input | 1 | 1 lets the selected tone reach the alarm pin |
| alarm_out | output | 1 | Alarm tone output |
| alarm_out_n | output | 1 | Inverse of alarm_out |

## Verification
On every cycle, the assertions check these behaviours: the gating by alarm enable, the complementary pin, the hold under clear, the freeze when counting is disabled, tone mode is off or no tick arrives, and the counter value just after each half boundary, including the restart at 1 under trim. Behaviours that span many cycles need the bench's scenarios. These are the actual half and full period lengths for several settings with and without trim, the 4096 Hz fallback waveform, the delay from clear release to the first rising edge, a write made mid-half that must not change the half in progress, and the stretching of the note when ticks are spaced out.

// File: rtl/tone_pkg.sv
package tone_pkg;

  typedef enum logic {
    HALF_LOW  = 1'b0,
    HALF_HIGH = 1'b1
  } half_e;

  // Alarm pin drive: gate, then pick the note or the fixed tone.
  function automatic logic alarm_drive(input logic en, input logic tone,
                                       input half_e note, input logic fixed);
    logic src;
    src = tone ? (note == HALF_HIGH) : fixed;
    return en & src;
  endfunction

endpackage

// File: rtl/tone_cfg_hold.sv
module tone_cfg_hold #(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] din,
  input  logic             load,
  output logic [CFG_W-1:0] active
);

  logic [CFG_W-1:0] pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
    end else if (wr) begin
      pending <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= '0;
    end else if (load) begin
      active <= pending;
    end
  end

endmodule

// File: rtl/tone_half_counter.sv
module tone_half_counter #(
  parameter int HALF_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic              clr,
  input  logic [HALF_W-1:0] limit,
  input  logic              trim,
  output logic [HALF_W:0]   cnt,
  output logic              half_end,
  output logic              trim_reload
);

  function automatic logic [HALF_W-1:0] bump(input logic [HALF_W-1:0] v);
    return v + {{(HALF_W-1){1'b0}}, 1'b1};
  endfunction

  logic [HALF_W-1:0] low_nxt;
  logic              step;
  logic [HALF_W-1:0] restart;

  assign low_nxt     = bump(cnt[HALF_W-1:0]);
  assign step        = tick & run & ~clr;
  assign half_end    = step & (low_nxt == limit);
  assign trim_reload = half_end & cnt[HALF_W] & trim;
  assign restart     = trim_reload ? {{(HALF_W-1){1'b0}}, 1'b1} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (half_end) begin
      cnt <= {~cnt[HALF_W], restart};
    end else if (step) begin
      cnt[HALF_W-1:0] <= low_nxt;
    end
  end

endmodule

// File: rtl/tone_fixed_div.sv
module tone_fixed_div #(
  parameter int DIV_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic wave
);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (tick) begin
      div_q <= div_q + {{(DIV_W-1){1'b0}}, 1'b1};
    end
  end

  assign wave = div_q[DIV_W-1];

endmodule

// File: rtl/tone_trim_gen.sv
module tone_trim_gen #(
  parameter int HALF_W = 7,
  parameter int DIV_W  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            tone_mode,
  input  logic            count_en,
  input  logic            clr,
  input  logic            set_wr,
  input  logic [HALF_W:0] set_data,
  input  logic            alarm_en,
  output logic            alarm_out,
  output logic            alarm_out_n
);
  import tone_pkg::*;

  localparam int CFG_W = HALF_W + 1;

  logic [CFG_W-1:0] act_cfg;
  logic [HALF_W:0]  note_cnt;
  logic             half_end;
  logic             trim_reload;
  logic             cfg_load;
  logic             run;
  logic             fixed_wave;
  half_e            note_half;

  assign run      = count_en & tone_mode;
  assign cfg_load = half_end | clr;

  tone_cfg_hold #(.CFG_W(CFG_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (set_wr),
    .din    (set_data),
    .load   (cfg_load),
    .active (act_cfg)
  );

  tone_half_counter #(.HALF_W(HALF_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .run         (run),
    .clr         (clr),
    .limit       (act_cfg[HALF_W-1:0]),
    .trim        (act_cfg[HALF_W]),
    .cnt         (note_cnt),
    .half_end    (half_end),
    .trim_reload (trim_reload)
  );

  tone_fixed_div #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .wave  (fixed_wave)
  );

  assign note_half   = half_e'(note_cnt[HALF_W]);
  assign alarm_out   = alarm_drive(alarm_en, tone_mode, note_half, fixed_wave);
  assign alarm_out_n = ~alarm_out;

endmodule

// File: rtl/tone_trim_chk.sv
module tone_trim_chk #(
  parameter int HALF_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic            tone_mode,
  input logic            count_en,
  input logic            clr,
  input logic            alarm_en,
  input logic            alarm_out,
  input logic            alarm_out_n,
  input logic [HALF_W:0] note_cnt,
  input logic            half_end,
  input logic [HALF_W:0] act_cfg
);

  a_r5_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_en |-> !alarm_out);

  a_r10_complement: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_out_n == !alarm_out);

  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (note_cnt == '0));

  a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !clr) |=> $stable(note_cnt));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tone_mode && !clr) |=> $stable(note_cnt));

  a_r11_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(note_cnt));

  a_r3_rise_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (half_end && !note_cnt[HALF_W]) |=> (note_cnt == {1'b1, {HALF_W{1'b0}}}));

  a_r4_trim_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (half_end && note_cnt[HALF_W] && act_cfg[HALF_W])
      |=> (note_cnt == {{HALF_W{1'b0}}, 1'b1}));

  a_r2_fall_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (half_end && note_cnt[HALF_W] && !act_cfg[HALF_W])
      |=> (note_cnt == '0));

endmodule

bind tone_trim_gen tone_trim_chk #(.HALF_W(HALF_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .tone_mode   (tone_mode),
  .count_en    (count_en),
  .clr         (clr),
  .alarm_en    (alarm_en),
  .alarm_out   (alarm_out),
  .alarm_out_n (alarm_out_n),
  .note_cnt    (note_cnt),
  .half_end    (half_end),
  .act_cfg     (act_cfg)
);

// File: tb/test_tone_trim_gen.sv
`timescale 1ns/1ps
module test_tone_trim_gen;

  logic       clk = 1'b0;
  logic       rst_n, tick, tone_mode, count_en, clr, set_wr, alarm_en;
  logic [7:0] set_data;
  logic       alarm_out, alarm_out_n;

  int n_checks = 0;
  int n_fail   = 0;
  int tick_div = 1;

  // setting (high byte) and expected period in ticks (low byte)
  localparam logic [15:0] VEC [0:6] = '{16'h0204, 16'h050A, 16'h8203,
                                        16'h8509, 16'h1020, 16'h901F,
                                        16'h7FFE};

  always #2.5 clk = ~clk;

  tone_trim_gen i_tone_trim_gen (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tone_mode(tone_mode),
    .count_en(count_en), .clr(clr), .set_wr(set_wr), .set_data(set_data),
    .alarm_en(alarm_en), .alarm_out(alarm_out), .alarm_out_n(alarm_out_n)
  );

  initial begin
    int ph = 0;
    tick = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      ph++;
      if (ph >= tick_div) begin
        ph = 0;
        tick = 1'b1;
      end else begin
        tick = 1'b0;
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_set(input logic [7:0] v);
    set_data = v;
    set_wr   = 1'b1;
    step();
    set_wr   = 1'b0;
  endtask

  task automatic restart_note(input logic [7:0] v);
    clr = 1'b1;
    write_set(v);
    step();
    step();
    clr = 1'b0;
  endtask

  task automatic measure(output int hi, output int lo);
    hi = 0;
    lo = 0;
    while (alarm_out) step();
    while (!alarm_out) step();
    while (alarm_out) begin step(); hi++; end
    while (!alarm_out) begin step(); lo++; end
  endtask

  initial begin
    #900000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int hi, lo, k, ones, flips;
    logic v;
    rst_n = 1'b0; tone_mode = 1'b1; count_en = 1'b0; clr = 1'b0;
    set_wr = 1'b0; set_data = 8'h00; alarm_en = 1'b1;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    chk("R1 alarm_out after reset", int'(alarm_out), 0);
    chk("R1 alarm_out_n after reset", int'(alarm_out_n), 1);

    // vector table: R2 / R3 / R4
    count_en = 1'b1;
    for (int i = 0; i < 7; i++) begin
      restart_note(VEC[i][15:8]);
      measure(hi, lo);
      chk("R3 high half", hi, int'(VEC[i][14:8]));
      if (VEC[i][15]) chk("R4 trimmed period", hi + lo, int'(VEC[i][7:0]));
      else            chk("R2 plain period", hi + lo, int'(VEC[i][7:0]));
    end

    // R10 while running
    restart_note(8'h03);
    flips = 0;
    for (int i = 0; i < 40; i++) begin
      step();
      if (alarm_out_n == alarm_out) flips++;
    end
    chk("R10 complement mismatches", flips, 0);

    // R5 gating
    alarm_en = 1'b0;
    ones = 0;
    for (int i = 0; i < 40; i++) begin
      step();
      if (alarm_out) ones++;
    end
    chk("R5 gated highs", ones, 0);
    chk("R10 complement while gated", int'(alarm_out_n), 1);
    alarm_en = 1'b1;

    // R7 clear hold and release
    clr = 1'b1;
    write_set(8'h06);
    ones = 0;
    for (int i = 0; i < 30; i++) begin
      step();
      if (alarm_out) ones++;
    end
    chk("R7 highs under clear", ones, 0);
    clr = 1'b0;
    k = 0;
    while (!alarm_out) begin step(); k++; end
    chk("R7 ticks to first rise", k, 6);

    // R8 freeze
    restart_note(8'h05);
    repeat (7) step();
    count_en = 1'b0;
    step();
    v = alarm_out;
    flips = 0;
    for (int i = 0; i < 40; i++) begin
      step();
      if (alarm_out != v) flips++;
    end
    chk("R8 changes while frozen", flips, 0);
    count_en = 1'b1;
    measure(hi, lo);
    chk("R8 period after resume", hi + lo, 10);

    // R9 write mid-half
    restart_note(8'h0A);
    while (alarm_out) step();
    while (!alarm_out) step();
    hi = 0;
    repeat (3) begin step(); hi++; end
    write_set(8'h03);
    hi++;
    while (alarm_out) begin step(); hi++; end
    chk("R9 half in progress keeps old length", hi, 10);
    lo = 0;
    while (!alarm_out) begin step(); lo++; end
    chk("R9 next half uses new length", lo, 3);
    hi = 0;
    while (alarm_out) begin step(); hi++; end
    chk("R9 following high half", hi, 3);

    // R11 spaced ticks
    tick_div = 4;
    restart_note(8'h02);
    measure(hi, lo);
    chk("R11 high clocks with spaced ticks", hi, 8);
    chk("R11 period clocks with spaced ticks", hi + lo, 16);
    tick_div = 1;

    // R6 fixed tone fallback
    tone_mode = 1'b0;
    measure(hi, lo);
    chk("R6 fallback high", hi, 8);
    chk("R6 fallback period", hi + lo, 16);
    alarm_en = 1'b0;
    step();
    chk("R5 fallback gated", int'(alarm_out), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule